// File: doc/BRIEF.md
# Indexed CRTC Register File with Key-Gated Write Protection

This block holds the display controller's 128 eight-bit CRTC registers behind a two-port indexed access scheme. A host first loads an index through the index port. Later data-port writes go to the register that the index selects, and the read port always shows the register that the index selects.

Each data write is qualified before it reaches storage. A lock bit in one timing register freezes the basic horizontal timing registers and restricts the overflow register to a single bit. Two key registers hold unlock patterns, and each pattern is compared through a mask. One key opens a window of extended registers. The other key opens everything from 0x40 up to the end of the file. A stricter comparison on the second key guards three sensitive registers. The key registers themselves can always be written. Reads are never gated. The way the register values drive display timing is outside this block.

Top module: `crtc_lock_regs`

## Requirements
- R1: After a synchronous active-low reset, every register and the index read back as 0x00, so every extended range starts locked.
- R2: An index write takes effect at the next clock edge. From then on `cur_index` shows that index and `rd_data` shows the selected register.
- R3: While bit 7 of register 0x11 is 1, data writes to registers 0x00 through 0x06 leave them unchanged.
- R4: While bit 7 of register 0x11 is 1, a data write to register 0x07 replaces only bit 4 and keeps bits 7:5 and 3:0.
- R5: Registers 0x2D through 0x3F, except 0x38 and 0x39, accept a write only when (register 0x38 AND 0xCC) equals 0x48.
- R6: Registers 0x40 through 0x7F accept a write only when (register 0x39 AND 0xE0) equals 0xA0.
- R7: Registers 0x36, 0x37 and 0x68 must also have (register 0x39 AND 0xE5) equal to 0xA5, on top of their range condition.
- R8: Data writes with an index of 0x80 or above change nothing, and `rd_data` reads 0x00 at such an index.
- R9: Key registers 0x38 and 0x39 always accept writes. Registers 0x08 through 0x2C, including 0x11, always accept writes.
- R10: A read returns the stored value whatever the lock and key state is.
- R11: When index and data writes occur in the same cycle, the data goes to the previously held index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| idx_we | input | 1 | Load the index register |
| idx_wdata | input | 8 | New index value |
| dat_we | input | 1 | Write the selected register |
| dat_wdata | input | 8 | Data for the selected register |
| cur_index | output | 8 | Currently held index |
| rd_data | output | 8 | Value of the selected register, or 0x00 when out of range |

## Verification
The bench sweeps all 256 index values with a distinct data byte at each. It repeats the sweep under seven key and lock combinations, then reads back the whole file. The combinations separate the cases that matter. With no keys set, only the free registers take writes. With the first key set and extra don't-care bits present, the masked compare on that key is shown. With the second key's coarse pattern but not the fine one, the 0x40+ range opens while 0x36, 0x37 and 0x68 stay shut. With full keys and the lock set, everything opens except the timing registers and the partial bits of 0x07. A separate pattern issues an index write and a data write in the same cycle to show which index the data lands on.

// File: rtl/crtc_lock_pkg.sv
// Package: shared widths, register indices and key patterns for the
// CRTC write-protect block. Assumes an 8-bit index and 8-bit registers.
package crtc_lock_pkg;
    localparam int DATA_W   = 8;
    localparam int INDEX_W  = 8;
    localparam int NUM_REGS = 128;

    typedef logic [DATA_W-1:0]  byte_t;
    typedef logic [INDEX_W-1:0] idx_t;

    // Fixed register positions the qualification logic decodes
    localparam idx_t IDX_TIMING_LAST = 8'h06;
    localparam idx_t IDX_OVERFLOW    = 8'h07;
    localparam idx_t IDX_LOCK        = 8'h11;
    localparam idx_t IDX_KEY_A       = 8'h38;
    localparam idx_t IDX_KEY_B       = 8'h39;
    localparam idx_t EXT_A_LO        = 8'h2D;
    localparam idx_t EXT_A_HI        = 8'h3F;
    localparam idx_t EXT_B_LO        = 8'h40;
    localparam idx_t DEEP_0          = 8'h36;
    localparam idx_t DEEP_1          = 8'h37;
    localparam idx_t DEEP_2          = 8'h68;

    localparam int LOCK_BIT    = 7;
    localparam int PARTIAL_BIT = 4;

    // Masked key comparisons
    localparam byte_t KEY_A_MASK = 8'hCC;
    localparam byte_t KEY_A_PAT  = 8'h48;
    localparam byte_t KEY_B_MASK = 8'hE0;
    localparam byte_t KEY_B_PAT  = 8'hA0;
    localparam byte_t DEEP_MASK  = 8'hE5;
    localparam byte_t DEEP_PAT   = 8'hA5;

    // Write-protection class of an index
    typedef enum logic [2:0] {
        CLS_FREE,
        CLS_TIMING,
        CLS_OVERFLOW,
        CLS_KEY,
        CLS_EXT_A,
        CLS_EXT_B,
        CLS_OUTSIDE
    } wr_class_e;
endpackage

// File: rtl/crtc_index_port.sv
// Index register: holds the index for the data and read ports.
// Assumes a synchronous active-low reset to index 0.
module crtc_index_port
    import crtc_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  idx_t wdata,
    output idx_t q
);
    // Load a new index on request
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= wdata;
    end
endmodule

// File: rtl/crtc_write_gate.sv
// Write qualification: classifies the target index and returns a per-bit
// write mask. It uses the current lock bit and key registers, so a
// write to a key register only takes effect on later writes. Pure
// combinational logic.
module crtc_write_gate
    import crtc_lock_pkg::*;
#(
    parameter int REGS = NUM_REGS
) (
    input  idx_t  idx,
    input  logic  lock_q,
    input  byte_t key_a_q,
    input  byte_t key_b_q,
    output byte_t wmask
);
    localparam byte_t ALL_BITS     = '1;
    localparam byte_t PARTIAL_MASK = byte_t'(1) << PARTIAL_BIT;

    wr_class_e cls;
    logic      key_a_ok;
    logic      key_b_ok;
    logic      deep_ok;
    logic      is_deep;

    // Evaluate the three masked key comparisons
    always_comb begin
        key_a_ok = (key_a_q & KEY_A_MASK) == KEY_A_PAT;
        key_b_ok = (key_b_q & KEY_B_MASK) == KEY_B_PAT;
        deep_ok  = (key_b_q & DEEP_MASK)  == DEEP_PAT;
        is_deep  = (idx == DEEP_0) || (idx == DEEP_1) || (idx == DEEP_2);
    end

    // Classify the target index by protection group
    always_comb begin
        if (int'(idx) >= REGS)
            cls = CLS_OUTSIDE;
        else if (idx <= IDX_TIMING_LAST)
            cls = CLS_TIMING;
        else if (idx == IDX_OVERFLOW)
            cls = CLS_OVERFLOW;
        else if (idx == IDX_KEY_A || idx == IDX_KEY_B)
            cls = CLS_KEY;
        else if (idx >= EXT_A_LO && idx <= EXT_A_HI)
            cls = CLS_EXT_A;
        else if (idx >= EXT_B_LO)
            cls = CLS_EXT_B;
        else
            cls = CLS_FREE;
    end

    // Turn class and key state into a per-bit write mask
    always_comb begin
        unique case (cls)
            CLS_OUTSIDE:  wmask = '0;
            CLS_TIMING:   wmask = lock_q ? '0 : ALL_BITS;
            CLS_OVERFLOW: wmask = lock_q ? PARTIAL_MASK : ALL_BITS;
            CLS_KEY:      wmask = ALL_BITS;
            CLS_EXT_A:    wmask = key_a_ok ? ALL_BITS : '0;
            CLS_EXT_B:    wmask = key_b_ok ? ALL_BITS : '0;
            default:      wmask = ALL_BITS;
        endcase
        if (is_deep && !deep_ok)
            wmask = '0;
    end
endmodule

// File: rtl/crtc_reg_store.sv
// Register storage: REGS bytes with a masked write port, a read mux that
// returns 0 outside the file, and taps for the lock bit and key bytes.
// Assumes a synchronous active-low reset that clears every byte.
module crtc_reg_store
    import crtc_lock_pkg::*;
#(
    parameter int REGS = NUM_REGS
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  byte_t wr_mask,
    input  byte_t wr_data,
    input  idx_t  rd_idx,
    output byte_t rd_data,
    output logic  lock_q,
    output byte_t key_a_q,
    output byte_t key_b_q
);
    localparam int SEL_W = $clog2(REGS);

    byte_t regs [REGS];

    for (genvar g = 0; g < REGS; g++) begin : g_reg
        logic hit;
        assign hit = wr_en && (wr_idx == idx_t'(g));
        // Merge the masked bits of a write into this entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (hit)
                regs[g] <= (regs[g] & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    // Return the selected byte, or zero outside the file
    always_comb begin
        if (int'(rd_idx) < REGS)
            rd_data = regs[rd_idx[SEL_W-1:0]];
        else
            rd_data = '0;
    end

    // Expose the bytes the write gate depends on
    always_comb begin
        lock_q  = regs[IDX_LOCK][LOCK_BIT];
        key_a_q = regs[IDX_KEY_A];
        key_b_q = regs[IDX_KEY_B];
    end
endmodule

// File: rtl/crtc_lock_regs.sv
// Top: indexed CRTC register file with lock-bit and key-gated writes.
// A data write uses the index held before the edge. Reads are never
// gated. Assumes a single clock and a synchronous active-low reset.
module crtc_lock_regs
    import crtc_lock_pkg::*;
#(
    parameter int REGS = NUM_REGS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idx_we,
    input  logic [INDEX_W-1:0]  idx_wdata,
    input  logic                dat_we,
    input  logic [DATA_W-1:0]   dat_wdata,
    output logic [INDEX_W-1:0]  cur_index,
    output logic [DATA_W-1:0]   rd_data
);
    idx_t  index_q;
    byte_t wmask;
    logic  lock_q;
    byte_t key_a_q;
    byte_t key_b_q;

    crtc_index_port i_index (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (idx_we),
        .wdata (idx_wdata),
        .q     (index_q)
    );

    crtc_write_gate #(.REGS(REGS)) i_gate (
        .idx     (index_q),
        .lock_q  (lock_q),
        .key_a_q (key_a_q),
        .key_b_q (key_b_q),
        .wmask   (wmask)
    );

    crtc_reg_store #(.REGS(REGS)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dat_we),
        .wr_idx  (index_q),
        .wr_mask (wmask),
        .wr_data (dat_wdata),
        .rd_idx  (index_q),
        .rd_data (rd_data),
        .lock_q  (lock_q),
        .key_a_q (key_a_q),
        .key_b_q (key_b_q)
    );

    assign cur_index = index_q;
endmodule

// File: rtl/crtc_lock_regs_chk.sv
// Checker: temporal properties of the write protection, seen at the
// top's ports and its lock and key taps. Attached by bind below.
module crtc_lock_regs_chk
    import crtc_lock_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  idx_we,
    input logic  dat_we,
    input byte_t dat_wdata,
    input idx_t  cur_index,
    input byte_t rd_data,
    input logic  lock_q,
    input byte_t key_a_q,
    input byte_t key_b_q
);
    logic plain_wr;
    assign plain_wr = dat_we && !idx_we;

    a_r3_timing_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_wr && cur_index <= 8'h06 && lock_q) |=> $stable(rd_data));

    a_r4_overflow_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_wr && cur_index == 8'h07 && lock_q) |=>
        (((rd_data & 8'hEF) == ($past(rd_data) & 8'hEF)) &&
         (rd_data[4] == $past(dat_wdata[4]))));

    a_r5_ext_a_shut: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_wr && cur_index >= 8'h2D && cur_index <= 8'h3F &&
         cur_index != 8'h38 && cur_index != 8'h39 &&
         ((key_a_q & 8'hCC) != 8'h48)) |=> $stable(rd_data));

    a_r6_ext_b_shut: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_wr && cur_index >= 8'h40 &&
         ((key_b_q & 8'hE0) != 8'hA0)) |=> $stable(rd_data));

    a_r7_deep_shut: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_wr && (cur_index == 8'h36 || cur_index == 8'h37 || cur_index == 8'h68) &&
         ((key_b_q & 8'hE5) != 8'hA5)) |=> $stable(rd_data));

    a_r8_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_index >= 8'h80) |-> (rd_data == 8'h00));

    a_r9_key_open: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_wr && (cur_index == 8'h38 || cur_index == 8'h39)) |=>
        (rd_data == $past(dat_wdata)));
endmodule

bind crtc_lock_regs crtc_lock_regs_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_we    (idx_we),
    .dat_we    (dat_we),
    .dat_wdata (dat_wdata),
    .cur_index (cur_index),
    .rd_data   (rd_data),
    .lock_q    (lock_q),
    .key_a_q   (key_a_q),
    .key_b_q   (key_b_q)
);

// File: tb/test_crtc_lock_regs.sv
// Bench: sweeps all indices under several key/lock settings against an
// arithmetic model of the write rules, then reads the whole file back.
module test_crtc_lock_regs;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_we = 1'b0;
    logic [7:0] idx_wdata = 8'h00;
    logic       dat_we = 1'b0;
    logic [7:0] dat_wdata = 8'h00;
    logic [7:0] cur_index;
    logic [7:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [7:0] model [128];

    crtc_lock_regs i_crtc_lock_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_we    (idx_we),
        .idx_wdata (idx_wdata),
        .dat_we    (dat_we),
        .dat_wdata (dat_wdata),
        .cur_index (cur_index),
        .rd_data   (rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
            $finish;
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp, int at);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at index %02h: actual %02h expected %02h", tag, at, act, exp);
        end
    endtask

    // Requirement tag for an index under the write rules
    function automatic string tag_of(int i);
        if (i >= 128) return "R8";
        if (i <= 6) return "R3";
        if (i == 7) return "R4";
        if (i == 'h38 || i == 'h39) return "R9";
        if (i == 'h36 || i == 'h37 || i == 'h68) return "R7";
        if (i >= 'h2D && i <= 'h3F) return "R5";
        if (i >= 'h40) return "R6";
        return "R9";
    endfunction

    // Expected value after a write, from the requirements
    function automatic logic [7:0] next_val(int i, logic [7:0] d);
        logic [7:0] old;
        logic lk;
        logic [7:0] ka;
        logic [7:0] kb;
        old = model[i];
        lk = model['h11][7];
        ka = model['h38];
        kb = model['h39];
        if (i <= 6 && lk) return old;
        if (i == 7 && lk) return {old[7:5], d[4], old[3:0]};
        if (i == 'h38 || i == 'h39) return d;
        if (i >= 'h2D && i <= 'h3F && (ka & 8'hCC) != 8'h48) return old;
        if (i >= 'h40 && (kb & 8'hE0) != 8'hA0) return old;
        if ((i == 'h36 || i == 'h37 || i == 'h68) && (kb & 8'hE5) != 8'hA5) return old;
        return d;
    endfunction

    task automatic set_index(int i);
        @(negedge clk);
        idx_we = 1'b1;
        idx_wdata = 8'(i);
        @(negedge clk);
        idx_we = 1'b0;
    endtask

    task automatic do_write(int i, logic [7:0] d);
        set_index(i);
        dat_we = 1'b1;
        dat_wdata = d;
        if (i < 128) model[i] = next_val(i, d);
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic read_chk(int i, string tag);
        set_index(i);
        check("R2", cur_index, 8'(i), i);
        check(tag, rd_data, (i < 128) ? model[i] : 8'h00, i);
    endtask

    task automatic scenario(logic [7:0] ka, logic [7:0] kb, logic [7:0] lk, int seed);
        do_write('h38, ka);
        do_write('h39, kb);
        do_write('h11, lk);
        for (int i = 0; i < 256; i++) begin
            if (i != 'h11 && i != 'h38 && i != 'h39)
                do_write(i, 8'(i * 7 + seed));
        end
        for (int i = 0; i < 128; i++) read_chk(i, tag_of(i));
        read_chk('h80, "R8");
        read_chk('hC3, "R8");
        read_chk('hFF, "R8");
    endtask

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", cur_index, 8'h00, 0);
        check("R1", rd_data, 8'h00, 0);
        for (int i = 0; i < 128; i++) read_chk(i, "R1");

        scenario(8'h00, 8'h00, 8'h00, 3);
        scenario(8'h48, 8'h00, 8'h80, 11);
        scenario(8'h7B, 8'hA1, 8'h80, 29);
        scenario(8'hFF, 8'hBF, 8'h00, 41);
        scenario(8'h48, 8'hA5, 8'h80, 53);
        scenario(8'hCC, 8'hE5, 8'h7F, 67);
        scenario(8'h4B, 8'hBD, 8'h00, 89);

        // R10: relock everything, then reads still return stored values
        do_write('h38, 8'h00);
        do_write('h39, 8'h00);
        do_write('h11, 8'h80);
        read_chk('h03, "R10");
        read_chk('h2E, "R10");
        read_chk('h45, "R10");
        read_chk('h68, "R10");

        // R11: index and data written in the same cycle
        do_write('h21, 8'h33);
        set_index('h20);
        @(negedge clk);
        idx_we = 1'b1;
        idx_wdata = 8'h21;
        dat_we = 1'b1;
        dat_wdata = 8'h5A;
        model['h20] = next_val('h20, 8'h5A);
        @(negedge clk);
        idx_we = 1'b0;
        dat_we = 1'b0;
        check("R11", cur_index, 8'h21, 'h21);
        check("R11", rd_data, 8'h33, 'h21);
        read_chk('h20, "R11");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule